// File: doc/BRIEF.md
# Vector Structure Load/Store Sequencer

The block moves one multi-register vector structure access between an internal bank of vector registers and a byte-addressed memory port. A decoded request names a base address register, a first vector register, a repeat count, a structure member count, an element size, the direction, and optional post-index writeback controls. The block walks three nested loops and issues one memory access per element. Each access carries an address, a byte count and a direction. A load places the returned bytes into a single lane of the target register. A store sends that lane's bytes to memory.

The vector registers, the general address registers and the stack pointer are held inside the block. A debug port writes and reads them, so a surrounding test can preset and inspect state. Index 31 on the address-register debug port is the stack pointer. Only one request is active at a time. A one-cycle completion pulse ends every request, including one rejected for stack misalignment.

Top module: `vstruct_seq`

## Requirements
- R1: A request is taken only when `busy` is low; `req_valid` while `busy` is high has no effect on accesses or registers.
- R2: Element size code k (0..3) gives elements of 2^k bytes. `mem_bytes` equals 2^k. Access i of a request goes to base + the sum of the byte counts of the accesses before it.
- R3: Accesses are ordered with the repeat index outermost, then the element (lane) index, then the structure member innermost. There is one access per (repeat, lane, member).
- R4: At the first member of each element the target register is (first register + repeat index) mod 32, and each later member uses the next register mod 32.
- R5: A load writes the returned low 2^k bytes into lane e of the target register, which is bits [e*8*2^k +: 8*2^k]. All other bits are left unchanged.
- R6: A store drives `mem_we`=1 and places lane e of the target register, zero-extended, on `mem_wdata`. Loads drive `mem_we`=0.
- R7: With base selector 31 the base address is the stack pointer; otherwise it is general register [selector].
- R8: With base selector 31 and a stack pointer whose low 4 bits are nonzero, the request makes no access and changes no register. It ends with `align_err` high for the one cycle in which `done` is high.
- R9: With writeback on, the base register (or stack pointer) becomes base + offset. The offset is general register [offset selector] when that selector is not 31, and the total bytes transferred when it is 31. With writeback off, the base is unchanged.
- R10: `mem_req` stays high with a stable address until `mem_ack`. `done` is high for exactly one cycle after the last access and any writeback.
- R11: After reset every register reads zero and `busy`, `done`, `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a request (taken only when idle) |
| req_base | input | 5 | Base address register selector, 31 = stack pointer |
| req_vt | input | 5 | First vector register |
| req_rpt_m1 | input | 2 | Repeat count minus one |
| req_selem_m1 | input | 2 | Structure member count minus one |
| req_esz | input | 2 | Element size code k, 2^k bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wback | input | 1 | Enable base writeback |
| req_offsel | input | 5 | Offset register selector, 31 = bytes transferred |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Byte address |
| mem_bytes | output | 4 | Bytes in this access |
| mem_wdata | output | 64 | Store data, low bytes valid |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Load data, low bytes valid |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Request rejected for stack misalignment (with done) |
| dbg_vwe | input | 1 | Debug vector register write |
| dbg_vidx | input | 5 | Debug vector write index |
| dbg_vwdata | input | 128 | Debug vector write data |
| dbg_vridx | input | 5 | Debug vector read index |
| dbg_vrdata | output | 128 | Debug vector read data |
| dbg_gwe | input | 1 | Debug address register write |
| dbg_gidx | input | 5 | Debug address register write index, 31 = stack pointer |
| dbg_gwdata | input | 64 | Debug address register write data |
| dbg_gridx | input | 5 | Debug address register read index |
| dbg_grdata | output | 64 | Debug address register read data |

## Verification
The bench builds the block with its default parameters: 32 vector registers of 128 bits, 64-bit addresses and a 64-bit maximum element. With these values all four element sizes are reachable, from sixteen byte lanes down to two doubleword lanes. A four-register request that starts at register 30 wraps through 31 into 0 and 1, and a three-member request that starts at 31 wraps the same way. Writebacks are exercised through a general register, through the stack pointer, with a register offset and with the transfer total. A misaligned stack pointer and a request arriving mid-run cover the rejected and ignored cases.

// File: rtl/vseq_pkg.sv
// Shared types for the vector structure sequencer.
// Assumes 5-bit register selectors where value 31 is special.
package vseq_pkg;
    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] SEL_SPECIAL = 5'd31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_WB   = 2'd2,
        ST_FIN  = 2'd3
    } vseq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] base;
        logic [SEL_W-1:0] vt;
        logic [1:0]       rpt_m1;
        logic [1:0]       selem_m1;
        logic [1:0]       esz;
        logic             store;
        logic             wback;
        logic [SEL_W-1:0] offsel;
    } vseq_cfg_t;
endpackage

// File: rtl/vseq_iter.sv
// Iteration engine: walks repeat > lane > member loops, tracks the target
// register (wrapping modulo NVREG) and the running byte offset.
// Assumes NVREG is a power of two; counts come in as "minus one" codes.
module vseq_iter #(
    parameter  int VLEN   = 128,
    parameter  int XLEN   = 64,
    parameter  int NVREG  = 32,
    localparam int VBYTES = VLEN / 8,
    localparam int EIW    = $clog2(VBYTES),
    localparam int VIW    = $clog2(NVREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            step,
    input  logic [VIW-1:0]  vt,
    input  logic [1:0]      rpt_m1,
    input  logic [1:0]      selem_m1,
    input  logic [1:0]      esz,
    output logic [VIW-1:0]  tt,
    output logic [EIW-1:0]  eidx,
    output logic [XLEN-1:0] offs,
    output logic [3:0]      ebytes,
    output logic            last
);
    logic [1:0]      r_q, s_q;
    logic [EIW-1:0]  e_q;
    logic [VIW-1:0]  tt_q;
    logic [XLEN-1:0] off_q;
    logic            s_last, e_last, r_last;

    // Position flags for the three loop levels.
    always_comb begin
        ebytes = 4'd1 << esz;
        s_last = (s_q == selem_m1);
        e_last = (e_q == EIW'((VBYTES >> esz) - 1));
        r_last = (r_q == rpt_m1);
        last   = s_last && e_last && r_last;
    end

    // Loop counters, target register and offset update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '0;
            s_q   <= '0;
            e_q   <= '0;
            tt_q  <= '0;
            off_q <= '0;
        end else if (start) begin
            r_q   <= '0;
            s_q   <= '0;
            e_q   <= '0;
            tt_q  <= vt;
            off_q <= '0;
        end else if (step) begin
            off_q <= off_q + XLEN'(ebytes);
            if (!s_last) begin
                s_q  <= s_q + 2'd1;
                tt_q <= tt_q + VIW'(1);
            end else begin
                s_q <= '0;
                if (!e_last) begin
                    e_q  <= e_q + EIW'(1);
                    tt_q <= vt + VIW'(r_q);
                end else begin
                    e_q  <= '0;
                    r_q  <= r_q + 2'd1;
                    tt_q <= vt + VIW'(r_q) + VIW'(1);
                end
            end
        end
    end

    assign tt   = tt_q;
    assign eidx = e_q;
    assign offs = off_q;
endmodule

// File: rtl/vseq_lane.sv
// Lane access: extracts lane eidx of a vector and builds the vector with that
// lane replaced, for each element size code, then selects by code.
// Assumes EMAX / 8 is a power of two and EMAX <= VLEN.
module vseq_lane #(
    parameter  int VLEN  = 128,
    parameter  int EMAX  = 64,
    localparam int EIW   = $clog2(VLEN / 8),
    localparam int NCODE = $clog2(EMAX / 8) + 1
) (
    input  logic [VLEN-1:0] vec,
    input  logic [EIW-1:0]  eidx,
    input  logic [1:0]      esz,
    input  logic [EMAX-1:0] wdata,
    output logic [EMAX-1:0] elem,
    output logic [VLEN-1:0] merged
);
    localparam int IW = $clog2(VLEN);

    logic [EMAX-1:0] cand_elem [NCODE];
    logic [VLEN-1:0] cand_vec  [NCODE];

    for (genvar k = 0; k < NCODE; k++) begin : g_size
        localparam int W  = 8 << k;
        localparam int NL = VLEN / W;
        logic [EIW-1:0]  li;
        logic [IW-1:0]   st;
        logic [VLEN-1:0] cv;
        // Lane start bit for this size, lane index folded into range.
        always_comb begin
            li = eidx & EIW'(NL - 1);
            st = IW'(int'(li) * W);
        end
        // Replace one lane of this size, keep the rest.
        always_comb begin
            cv = vec;
            cv[st +: W] = wdata[W-1:0];
        end
        assign cand_elem[k] = EMAX'(vec[st +: W]);
        assign cand_vec[k]  = cv;
    end

    // Pick the variant for the requested element size.
    always_comb begin
        elem   = cand_elem[esz];
        merged = cand_vec[esz];
    end
endmodule

// File: rtl/vseq_regs.sv
// Register storage: vector bank and address registers (entry 31 is the
// stack pointer). Engine write ports take priority over debug writes.
module vseq_regs #(
    parameter  int VLEN  = 128,
    parameter  int XLEN  = 64,
    parameter  int NVREG = 32,
    localparam int VIW   = $clog2(NVREG),
    localparam int NGPR  = 32,
    localparam int GIW   = $clog2(NGPR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            v_we_e,
    input  logic [VIW-1:0]  v_idx_e,
    input  logic [VLEN-1:0] v_wd_e,
    input  logic            v_we_d,
    input  logic [VIW-1:0]  v_idx_d,
    input  logic [VLEN-1:0] v_wd_d,
    input  logic [VIW-1:0]  v_ra,
    output logic [VLEN-1:0] v_rda,
    input  logic [VIW-1:0]  v_rb,
    output logic [VLEN-1:0] v_rdb,
    input  logic            g_we_e,
    input  logic [GIW-1:0]  g_idx_e,
    input  logic [XLEN-1:0] g_wd_e,
    input  logic            g_we_d,
    input  logic [GIW-1:0]  g_idx_d,
    input  logic [XLEN-1:0] g_wd_d,
    input  logic [GIW-1:0]  g_ra,
    output logic [XLEN-1:0] g_rda,
    input  logic [GIW-1:0]  g_rb,
    output logic [XLEN-1:0] g_rdb,
    input  logic [GIW-1:0]  g_rc,
    output logic [XLEN-1:0] g_rdc
);
    logic [VLEN-1:0] vreg_q [NVREG];
    logic [XLEN-1:0] greg_q [NGPR];

    // Vector bank update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVREG; i++) vreg_q[i] <= '0;
        end else if (v_we_e) begin
            vreg_q[v_idx_e] <= v_wd_e;
        end else if (v_we_d) begin
            vreg_q[v_idx_d] <= v_wd_d;
        end
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGPR; i++) greg_q[i] <= '0;
        end else if (g_we_e) begin
            greg_q[g_idx_e] <= g_wd_e;
        end else if (g_we_d) begin
            greg_q[g_idx_d] <= g_wd_d;
        end
    end

    assign v_rda = vreg_q[v_ra];
    assign v_rdb = vreg_q[v_rb];
    assign g_rda = greg_q[g_ra];
    assign g_rdb = greg_q[g_rb];
    assign g_rdc = greg_q[g_rc];
endmodule

// File: rtl/vstruct_seq.sv
// Vector structure load/store sequencer top. Accepts one decoded request
// while idle, checks stack alignment, steps through every element access
// over a request/acknowledge memory port, then optionally writes back the
// base. Assumes the memory holds mem_req/mem_ack in the usual way.
module vstruct_seq
    import vseq_pkg::*;
#(
    parameter  int VLEN  = 128,
    parameter  int XLEN  = 64,
    parameter  int NVREG = 32,
    parameter  int EMAX  = 64,
    localparam int VIW   = $clog2(NVREG),
    localparam int BW    = $clog2(EMAX / 8) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEL_W-1:0] req_base,
    input  logic [VIW-1:0]   req_vt,
    input  logic [1:0]       req_rpt_m1,
    input  logic [1:0]       req_selem_m1,
    input  logic [1:0]       req_esz,
    input  logic             req_store,
    input  logic             req_wback,
    input  logic [SEL_W-1:0] req_offsel,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [BW-1:0]    mem_bytes,
    output logic [EMAX-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [EMAX-1:0]  mem_rdata,
    output logic             done,
    output logic             align_err,
    input  logic             dbg_vwe,
    input  logic [VIW-1:0]   dbg_vidx,
    input  logic [VLEN-1:0]  dbg_vwdata,
    input  logic [VIW-1:0]   dbg_vridx,
    output logic [VLEN-1:0]  dbg_vrdata,
    input  logic             dbg_gwe,
    input  logic [SEL_W-1:0] dbg_gidx,
    input  logic [XLEN-1:0]  dbg_gwdata,
    input  logic [SEL_W-1:0] dbg_gridx,
    output logic [XLEN-1:0]  dbg_grdata
);
    localparam int ALW = $clog2(VLEN / 8);
    localparam int EIW = $clog2(VLEN / 8);

    vseq_state_e     state_q;
    vseq_cfg_t       cfg_q;
    logic [XLEN-1:0] base_q;
    logic            err_q;

    logic [XLEN-1:0] base_rd, off_rd, offs, wb_val;
    logic [VLEN-1:0] tgt_vec, new_vec;
    logic [EMAX-1:0] lane_elem;
    logic [VIW-1:0]  tt, it_vt;
    logic [EIW-1:0]  eidx;
    logic [3:0]      ebytes;
    logic            it_last, accept, misalign, it_start, it_step, lane_we, wb_we;

    // Request acceptance and stack alignment test.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        misalign = (req_base == SEL_SPECIAL) && (base_rd[ALW-1:0] != '0);
        it_start = accept && !misalign;
        it_step  = (state_q == ST_ACC) && mem_ack;
        it_vt    = (state_q == ST_IDLE) ? req_vt : cfg_q.vt;
        lane_we  = it_step && !cfg_q.store;
        wb_we    = (state_q == ST_WB);
        wb_val   = base_q + ((cfg_q.offsel != SEL_SPECIAL) ? off_rd : offs);
    end

    // Sequencer state, latched request and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            base_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    cfg_q   <= '{base: req_base, vt: req_vt, rpt_m1: req_rpt_m1,
                                 selem_m1: req_selem_m1, esz: req_esz,
                                 store: req_store, wback: req_wback,
                                 offsel: req_offsel};
                    base_q  <= base_rd;
                    err_q   <= misalign;
                    state_q <= misalign ? ST_FIN : ST_ACC;
                end
                ST_ACC: if (mem_ack && it_last)
                    state_q <= cfg_q.wback ? ST_WB : ST_FIN;
                ST_WB:   state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    vseq_iter #(.VLEN(VLEN), .XLEN(XLEN), .NVREG(NVREG)) u_iter (
        .clk(clk), .rst_n(rst_n), .start(it_start), .step(it_step),
        .vt(it_vt), .rpt_m1(cfg_q.rpt_m1), .selem_m1(cfg_q.selem_m1),
        .esz(cfg_q.esz), .tt(tt), .eidx(eidx), .offs(offs),
        .ebytes(ebytes), .last(it_last)
    );

    vseq_lane #(.VLEN(VLEN), .EMAX(EMAX)) u_lane (
        .vec(tgt_vec), .eidx(eidx), .esz(cfg_q.esz), .wdata(mem_rdata),
        .elem(lane_elem), .merged(new_vec)
    );

    vseq_regs #(.VLEN(VLEN), .XLEN(XLEN), .NVREG(NVREG)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .v_we_e(lane_we), .v_idx_e(tt), .v_wd_e(new_vec),
        .v_we_d(dbg_vwe), .v_idx_d(dbg_vidx), .v_wd_d(dbg_vwdata),
        .v_ra(tt), .v_rda(tgt_vec), .v_rb(dbg_vridx), .v_rdb(dbg_vrdata),
        .g_we_e(wb_we), .g_idx_e(cfg_q.base), .g_wd_e(wb_val),
        .g_we_d(dbg_gwe), .g_idx_d(dbg_gidx), .g_wd_d(dbg_gwdata),
        .g_ra(req_base), .g_rda(base_rd), .g_rb(cfg_q.offsel), .g_rdb(off_rd),
        .g_rc(dbg_gridx), .g_rdc(dbg_grdata)
    );

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_ACC);
    assign mem_we    = cfg_q.store;
    assign mem_addr  = base_q + offs;
    assign mem_bytes = BW'(ebytes);
    assign mem_wdata = lane_elem;
    assign done      = (state_q == ST_FIN);
    assign align_err = (state_q == ST_FIN) && err_q;
endmodule

// File: rtl/vstruct_seq_chk.sv
// Protocol checker for vstruct_seq, attached by bind below.
module vstruct_seq_chk #(
    parameter int XLEN = 64,
    parameter int BW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_ack,
    input logic [XLEN-1:0] mem_addr,
    input logic [BW-1:0]   mem_bytes,
    input logic            done,
    input logic            align_err
);
    // R10: completion pulse lasts one cycle.
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: request held with stable address until acknowledged.
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_bytes)));

    // R2: byte count is a single power of two.
    a_r2_bytes_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_bytes) == 1));

    // R2: next access follows the previous one contiguously.
    a_r2_addr_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req ||
            mem_addr == $past(mem_addr) + {{(XLEN-BW){1'b0}}, $past(mem_bytes)}));

    // R8: alignment error only reported with completion.
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> done);

    // R1: idle block makes no access and no completion.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    // R1: a request seen while idle is taken.
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
endmodule

bind vstruct_seq vstruct_seq_chk #(.XLEN(XLEN), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_bytes(mem_bytes), .done(done), .align_err(align_err)
);

// File: tb/sim_vstruct_seq.sv
// Scoreboard bench: run_op computes the expected accesses and final state,
// the memory monitor pops and compares each access as it is issued.
module sim_vstruct_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ = 1024;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [4:0]   req_base, req_vt, req_offsel;
    logic [1:0]   req_rpt_m1, req_selem_m1, req_esz;
    logic         req_store, req_wback;
    logic         busy, mem_req, mem_we, mem_ack, done, align_err;
    logic [63:0]  mem_addr, mem_wdata, mem_rdata;
    logic [3:0]   mem_bytes;
    logic         dbg_vwe, dbg_gwe;
    logic [4:0]   dbg_vidx, dbg_vridx, dbg_gidx, dbg_gridx;
    logic [127:0] dbg_vwdata, dbg_vrdata;
    logic [63:0]  dbg_gwdata, dbg_grdata;

    typedef struct {
        bit          we;
        logic [63:0] addr;
        logic [3:0]  bytes;
        logic [63:0] wdata;
    } acc_t;

    acc_t         exp_q[$];
    logic [7:0]   mem_m   [MEMSZ];
    logic [7:0]   exp_mem [MEMSZ];
    logic [127:0] vsh [32];
    logic [63:0]  gsh [32];
    int n_chk = 0, n_fail = 0, n_extra = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vstruct_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_vt(req_vt), .req_rpt_m1(req_rpt_m1), .req_selem_m1(req_selem_m1),
        .req_esz(req_esz), .req_store(req_store), .req_wback(req_wback),
        .req_offsel(req_offsel), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .align_err(align_err),
        .dbg_vwe(dbg_vwe), .dbg_vidx(dbg_vidx), .dbg_vwdata(dbg_vwdata),
        .dbg_vridx(dbg_vridx), .dbg_vrdata(dbg_vrdata), .dbg_gwe(dbg_gwe),
        .dbg_gidx(dbg_gidx), .dbg_gwdata(dbg_gwdata), .dbg_gridx(dbg_gridx),
        .dbg_grdata(dbg_grdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Memory monitor: acknowledges each request one cycle later and compares it.
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (exp_q.size() == 0) begin
                    n_extra++;
                    chk(1'b0, "R1", "unexpected access", mem_addr, '0);
                end else begin
                    acc_t it;
                    it = exp_q.pop_front();
                    chk(mem_addr == it.addr && mem_we == it.we && mem_bytes == it.bytes,
                        "R3", "access we/bytes/addr",
                        {mem_we, mem_bytes, mem_addr}, {it.we, it.bytes, it.addr});
                    if (it.we)
                        chk(mem_wdata == it.wdata, "R6", "store lane data", mem_wdata, it.wdata);
                end
                mem_rdata = '0;
                for (int b = 0; b < 8; b++) begin
                    if (b < int'(mem_bytes)) begin
                        if (mem_we) mem_m[10'(mem_addr + 64'(b))] = mem_wdata[8*b +: 8];
                        else mem_rdata[8*b +: 8] = mem_m[10'(mem_addr + 64'(b))];
                    end
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    task automatic vset(input int i, input logic [127:0] v);
        dbg_vwe = 1'b1; dbg_vidx = 5'(i); dbg_vwdata = v;
        @(posedge clk); #1;
        dbg_vwe = 1'b0;
        vsh[i] = v;
    endtask

    task automatic gset(input int i, input logic [63:0] v);
        dbg_gwe = 1'b1; dbg_gidx = 5'(i); dbg_gwdata = v;
        @(posedge clk); #1;
        dbg_gwe = 1'b0;
        gsh[i] = v;
    endtask

    // Compare all visible state against the shadow model.
    task automatic check_state(input string tag);
        bit vok = 1'b1, gok = 1'b1, mok = 1'b1;
        logic [127:0] va = '0, ve = '0;
        logic [63:0] ga = '0, ge = '0;
        for (int i = 0; i < 32; i++) begin
            dbg_vridx = 5'(i); dbg_gridx = 5'(i);
            #1;
            if (vok && dbg_vrdata !== vsh[i]) begin vok = 1'b0; va = dbg_vrdata; ve = vsh[i]; end
            if (gok && dbg_grdata !== gsh[i]) begin gok = 1'b0; ga = dbg_grdata; ge = gsh[i]; end
        end
        for (int a = 0; a < MEMSZ; a++) if (mem_m[a] !== exp_mem[a]) mok = 1'b0;
        chk(vok, "R5", {tag, " vector registers"}, va, ve);
        chk(gok, "R9", {tag, " address registers"}, ga, ge);
        chk(mok, "R6", {tag, " memory contents"}, mok, 1);
    endtask

    // Driver: predicts accesses and final state, issues the request, waits.
    task automatic run_op(input int base, input int vt, input int rpt, input int selem,
                          input int esz, input bit st, input bit wb, input int offsel,
                          input bit poke, input string tag);
        logic [63:0] ba = gsh[base];
        logic [63:0] offs = 0;
        bit experr = (base == 31) && (ba[3:0] != 4'd0);
        int eb = 1 << esz;
        int nel = 16 / eb;
        int cnt = 0;
        if (!experr) begin
            for (int r = 0; r < rpt; r++) begin
                for (int e = 0; e < nel; e++) begin
                    int tt = (vt + r) % 32;
                    for (int s = 0; s < selem; s++) begin
                        acc_t it;
                        it.we = st; it.addr = ba + offs; it.bytes = 4'(eb); it.wdata = '0;
                        for (int b = 0; b < eb; b++) begin
                            if (st) begin
                                it.wdata[8*b +: 8] = vsh[tt][(e*eb + b)*8 +: 8];
                                exp_mem[10'(ba + offs + 64'(b))] = vsh[tt][(e*eb + b)*8 +: 8];
                            end else begin
                                vsh[tt][(e*eb + b)*8 +: 8] = exp_mem[10'(ba + offs + 64'(b))];
                            end
                        end
                        exp_q.push_back(it);
                        offs = offs + 64'(eb);
                        tt = (tt + 1) % 32;
                    end
                end
            end
            if (wb) gsh[base] = ba + ((offsel != 31) ? gsh[offsel] : offs);
        end
        req_base = 5'(base); req_vt = 5'(vt); req_rpt_m1 = 2'(rpt - 1);
        req_selem_m1 = 2'(selem - 1); req_esz = 2'(esz); req_store = st;
        req_wback = wb; req_offsel = 5'(offsel); req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            req_base = 5'd1; req_vt = 5'd7; req_store = 1'b1; req_wback = 1'b1;
            req_offsel = 5'd31; req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
        while (!done && cnt < 5000) begin
            @(posedge clk); #1;
            cnt++;
        end
        chk(done == 1'b1, "R10", {tag, " completion seen"}, done, 1);
        chk(align_err == experr, "R8", {tag, " alignment flag"}, align_err, experr);
        chk(exp_q.size() == 0, "R3", {tag, " all accesses issued"}, exp_q.size(), 0);
        @(posedge clk); #1;
        chk(done == 1'b0 && busy == 1'b0, "R10", {tag, " done is one cycle"}, {done, busy}, 0);
        if (poke) begin
            repeat (10) @(posedge clk);
            #1;
            chk(n_extra == 0 && !busy, "R1", {tag, " mid-run request ignored"}, n_extra, 0);
        end
        check_state(tag);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_vt = '0; req_rpt_m1 = '0;
        req_selem_m1 = '0; req_esz = '0; req_store = 1'b0; req_wback = 1'b0;
        req_offsel = '0; dbg_vwe = 1'b0; dbg_vidx = '0; dbg_vwdata = '0;
        dbg_vridx = 5'd5; dbg_gwe = 1'b0; dbg_gidx = '0; dbg_gwdata = '0; dbg_gridx = 5'd1;
        for (int a = 0; a < MEMSZ; a++) begin
            mem_m[a] = 8'(a * 13 + 5);
            exp_mem[a] = 8'(a * 13 + 5);
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R11: reset state.
        chk(!busy && !done && !mem_req, "R11", "reset control outputs", {busy, done, mem_req}, 0);
        chk(dbg_vrdata == '0 && dbg_grdata == '0, "R11", "reset registers", {dbg_vrdata[63:0], dbg_grdata}, 0);
        for (int i = 0; i < 32; i++) begin
            vsh[i] = '0;
            gsh[i] = '0;
        end
        for (int i = 0; i < 32; i++)
            vset(i, {16{8'(i * 7 + 3)}} ^ 128'h0123456789abcdef_fedcba9876543210);
        gset(1, 64'h100);
        gset(2, 64'h40);
        gset(3, 64'h200);
        gset(31, 64'h300);
        // R2 R3 R5 R7: single register, byte lanes, general base.
        run_op(1, 5, 1, 1, 0, 1'b0, 1'b0, 31, 1'b0, "T1 load one reg");
        // R4: four registers wrapping 30,31,0,1.
        run_op(3, 30, 4, 1, 0, 1'b0, 1'b0, 31, 1'b0, "T2 load wrap");
        // R6 R9: interleaved word store, writeback by transfer total.
        run_op(1, 10, 1, 2, 2, 1'b1, 1'b1, 31, 1'b0, "T3 store words");
        // R4 R9: three members from 31, doublewords, register offset writeback.
        run_op(3, 31, 1, 3, 3, 1'b0, 1'b1, 2, 1'b0, "T4 load dwords");
        // R7 R9: stack pointer base, halfwords, repeat two, members two.
        run_op(31, 12, 2, 2, 1, 1'b0, 1'b1, 31, 1'b0, "T5 stack base");
        // R8: misaligned stack pointer rejected.
        gset(31, 64'h308);
        run_op(31, 4, 1, 1, 0, 1'b0, 1'b1, 31, 1'b0, "T6 misaligned");
        // R1: second request arrives mid-run.
        run_op(3, 20, 1, 1, 1, 1'b0, 1'b0, 31, 1'b1, "T7 busy ignore");
        // R9: store without writeback leaves base unchanged.
        run_op(1, 0, 4, 1, 0, 1'b1, 1'b0, 31, 1'b0, "T8 store no wb");
        summary();
        $finish;
    end
endmodule